// File: doc/BRIEF.md
# Trigger Activity Timeout Detector

This block tells a sweep controller whether triggers are arriving often enough. It divides the system clock down to a slow periodic tick, which is 50 ms at the default setting. It then uses two state bits, updated on that tick, to decide between "triggers present" and "triggers absent". The downstream sweep gate controller reads the `triggered` output. When the output is low, that controller lets sweeps free-run. A second output drives a ready indicator that is lit while triggers are being seen.

The trigger pin is asynchronous. It passes through a two-flop synchronizer, and only its rising edge counts as a trigger event. The two state bits are encoded as a three-state machine:

- `ST_IDLE`: no trigger seen for a full tick interval. The output is low.
- `ST_SEEN`: a trigger was captured since the last tick.
- `ST_ARMED`: one tick has passed with no trigger, but the output is still high.

The machine has four named transitions:

- `CAPTURE`: any state goes to `ST_SEEN` on an accepted trigger event.
- `AGE`: `ST_SEEN` goes to `ST_ARMED` on a tick.
- `EXPIRE`: `ST_ARMED` goes to `ST_IDLE` on a tick.
- `DISARM`: in single-sweep mode, a trigger event moves `ST_SEEN` to `ST_ARMED`, because the capture input is held low in that mode.

As a result, the output drops only after a whole tick interval with no trigger. Any accepted trigger restores it at once.

Top module: `trig_watch`

## Requirements
- R1: While `rst_n` is low, and right after reset, `triggered` and `ready_lamp` are 0 and the machine is in `ST_IDLE`.
- R2: The internal tick fires on the TICK_DIV-th rising clock edge after reset release, and on every TICK_DIV-th edge after that.
- R3: If `trig_in` rises between edge k-1 and edge k, the resulting event acts on the state at edge k+2. Only a rising edge makes an event, so holding `trig_in` high gives exactly one event.
- R4: When `single_mode` is 0, a trigger event takes any state to `ST_SEEN` (CAPTURE), and `triggered` is 1 from the next cycle.
- R5: A tick in `ST_SEEN` with no accepted event moves the machine to `ST_ARMED` (AGE), and `triggered` stays 1.
- R6: A tick in `ST_ARMED` with no accepted event moves the machine to `ST_IDLE` (EXPIRE), and `triggered` becomes 0. A tick in `ST_IDLE` leaves it there.
- R7: When an accepted event and a tick land on the same edge, the event wins and the state becomes `ST_SEEN`.
- R8: `ready_lamp` equals `triggered` in every cycle.
- R9: When `single_mode` is 1, trigger events never raise `triggered`. An event in `ST_SEEN` moves the machine to `ST_ARMED` (DISARM). `single_mode` is sampled on the clock edge without synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger pulse |
| single_mode | input | 1 | 1 selects single-sweep mode (capture disabled) |
| triggered | output | 1 | 1 while triggers have been seen within the timeout window |
| ready_lamp | output | 1 | Ready indicator drive, mirrors `triggered` |

## Verification
A wrong state bit shows up at `triggered` only at tick boundaries or one cycle after a trigger event. For example, a stuck second stage shows up as a drop that comes one tick early or never comes. A wrong tick phase moves every expiry by whole cycles. For these reasons the bench keeps a cycle-exact model of the tick, the synchronizer latency and the two stages. It compares both outputs in every cycle, across all trigger phases within two tick periods and all three pulse widths, in both modes. Any fault therefore appears within one tick interval of the stimulus that exposes it.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEEN  = 2'd1,
        ST_ARMED = 2'd2
    } tw_state_e;
endpackage

// File: rtl/tw_tick_div.sv
module tw_tick_div #(
    parameter int TICK_DIV = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = rst_n && (cnt == LAST);

    // R2
    tick_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tw_edge_sync.sv
module tw_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q && !prev_q;

    // R3
    rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tw_stage_fsm.sv
module tw_stage_fsm
    import tw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig_evt,
    input  logic single_mode,
    output logic triggered,
    output logic lamp
);
    tw_state_e state, state_nx;
    logic      capture;

    assign capture = trig_evt && !single_mode;

    always_comb begin
        state_nx = state;
        if (capture) begin
            state_nx = ST_SEEN;                        // CAPTURE
        end else begin
            unique case (state)
                ST_SEEN: begin
                    if (tick || trig_evt) state_nx = ST_ARMED;  // AGE / DISARM
                end
                ST_ARMED: begin
                    if (tick) state_nx = ST_IDLE;      // EXPIRE
                end
                ST_IDLE:  state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_SEEN, ST_ARMED: begin triggered = 1'b1; lamp = 1'b1; end
            default:           begin triggered = 1'b0; lamp = 1'b0; end
        endcase
    end

    // R4
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && !single_mode) |=> (state == ST_SEEN && triggered));
    // R5
    age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEN && tick && !trig_evt) |=> (state == ST_ARMED && triggered));
    // R6
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && tick && !(trig_evt && !single_mode)) |=> !triggered);
    // R9
    single_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && !triggered) |=> !triggered);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE));
endmodule

// File: rtl/trig_watch.sv
module trig_watch #(
    parameter int TICK_DIV = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic single_mode,
    output logic triggered,
    output logic ready_lamp
);
    logic tick, trig_evt;

    tw_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tw_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_in),
        .rise  (trig_evt)
    );

    tw_stage_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .trig_evt    (trig_evt),
        .single_mode (single_mode),
        .triggered   (triggered),
        .lamp        (ready_lamp)
    );

    // R8
    lamp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_lamp == triggered);
endmodule

// File: tb/trig_watch_bench.sv
module trig_watch_bench;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic single_mode = 1'b0;
    logic triggered, ready_lamp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_watch #(.TICK_DIV(DIV)) u_trig_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .single_mode (single_mode),
        .triggered   (triggered),
        .ready_lamp  (ready_lamp)
    );

    // Reference model: stage bits A (seen) and B (no trigger)
    int  n_edge = 0;
    bit  h1 = 0, h2 = 0, h3 = 0;
    bit  ref_a = 0, ref_b = 1;
    string tag = "R1";

    always @(posedge clk) begin
        bit evt, tk;
        if (!rst_n) begin
            n_edge = 0; h1 = 0; h2 = 0; h3 = 0;
            ref_a = 0; ref_b = 1; tag = "R1";
        end else begin
            n_edge = n_edge + 1;
            tk  = (n_edge % DIV) == 0;               // R2 tick phase
            evt = h2 && !h3;                         // R3 latency k+2
            h3 = h2; h2 = h1; h1 = trig_in;
            if (evt && !single_mode) begin
                ref_a = 1; ref_b = 0;
                tag = tk ? "R7" : "R4";
            end else begin
                if (tk) begin
                    tag = ref_a ? "R5" : "R6";
                    ref_b = !ref_a;
                    ref_a = 0;
                end
                if (evt && single_mode) begin
                    ref_a = 0;
                    tag = "R9";
                end
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Lockstep comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, triggered, !ref_b);
            check("R8", ready_lamp, triggered);
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int width);
        trig_in = 1'b1;
        wait_cycles(width);
        trig_in = 1'b0;
    endtask

    initial begin
        wait_cycles(4);
        check("R1", triggered, 1'b0);
        check("R1", ready_lamp, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", triggered, 1'b0);
        wait_cycles(3 * DIV);
        for (int sm = 0; sm < 2; sm++) begin
            for (int w = 1; w <= 3; w++) begin
                for (int ph = 0; ph < 2 * DIV; ph++) begin
                    single_mode = sm[0];
                    wait_cycles(ph);
                    pulse(w);
                    wait_cycles(ph % 3);
                    pulse(1);                        // back-to-back events
                    wait_cycles(3 * DIV + ph);       // long enough to expire
                end
            end
            // In single mode, establish SEEN first, then disarm it
            single_mode = 1'b0;
            pulse(1);
            wait_cycles(4);
            single_mode = sm[0];
            pulse(1);
            wait_cycles(4 * DIV);
        end
        // R3: held-high input yields one event only
        single_mode = 1'b0;
        trig_in = 1'b1;
        wait_cycles(5 * DIV);
        check("R3", triggered, 1'b0);
        trig_in = 1'b0;
        wait_cycles(2 * DIV);
        // R1: re-entering reset clears the state
        pulse(1);
        wait_cycles(4);
        check("R4", triggered, 1'b1);
        rst_n = 1'b0;
        wait_cycles(2);
        check("R1", triggered, 1'b0);
        check("R1", ready_lamp, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule